// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block turns a recovered serial HDLC bit stream into frame bytes. A bit is taken on each clock cycle in which the receive strobe is high. The block looks for the 0x7E flag pattern to find frame boundaries and deletes the zero bits that the transmitter stuffed into the stream. It builds octets and runs a CRC-16 check over every frame bit. Each frame also passes through a 16-bit masked address filter that compares against four match values.

Accepted frames come out on a byte port that has a valid/ready handshake. First and last markers travel with the bytes. The two FCS bytes are removed before delivery, so the payload appears three octets after it is received. When a reported frame closes, the status port gives a one-cycle word with the delivered length and an error vector. A frame that the filter rejects produces no output and instead advances a discard counter.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The flag pattern 0x7E (bits received 0,1,1,1,1,1,1,0) opens and closes frames, and a closing flag may also open the next frame. Octets are assembled with the first received bit as bit 0. Delivered bytes keep their order. out_first_o is set on the first byte of a frame, and out_last_o is set on the final byte of a good-length aligned frame. stat_valid_o pulses for one cycle for each reported frame.
- R2: A zero that follows five consecutive ones is removed from the data.
- R3: The CRC register is preset to 0xFFFF and steps by the reflected CCITT polynomial (0x8408) on every frame bit, FCS included. If the final value of an aligned, non-aborted, non-oversize frame is not 0xF0B8, status bit 0 (CRC error) is set.
- R4: stat_o[LEN_W+4:5] holds the number of data bytes delivered for the frame. For a clean frame this is the byte count minus the 2 FCS bytes, and the FCS bytes are never delivered.
- R5: A frame whose byte count, FCS included, exceeds max_len_i sets status bit 3 (oversize). Bytes past the limit are not delivered, and max_len_i minus 3 bytes come out.
- R6: If the number of frame bits before the closing flag is not a multiple of 8, status bit 2 (non-octet) is set and no last byte is flushed.
- R7: Seven consecutive ones inside a frame end that frame with status bit 1 (abort) set. The block then ignores the line until the next flag.
- R8: If a byte becomes due while the output holds an unaccepted byte, the new byte is dropped and status bit 4 (overrun) is set. The held byte stays stable until it is accepted.
- R9: A frame is accepted when ((addr ^ match[k]) & addr_mask_i) == 0 for any k of the four. Here addr = {second byte, first byte} and match[k] = addr_match_i[16k+15:16k]. A mask of 0x0000 accepts every frame.
- R10: A rejected frame of at least 4 bytes delivers no bytes and no status, and it increments disc_cnt_o by one.
- R11: A frame with fewer than 4 bytes between flags is dropped silently: no bytes, no status, no count.
- R12: After reset, out_valid_o and stat_valid_o are low and disc_cnt_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive bit strobe |
| rx_bit_i | input | 1 | Received line bit |
| max_len_i | input | LEN_W | Maximum frame bytes including FCS |
| addr_mask_i | input | 16 | Address compare mask |
| addr_match_i | input | 16*N_ADDR | Address match values, entry k at bits 16k+15:16k |
| out_ready_i | input | 1 | Byte sink ready |
| out_valid_o | output | 1 | Byte valid |
| out_data_o | output | 8 | Frame byte |
| out_first_o | output | 1 | First byte of frame |
| out_last_o | output | 1 | Final byte of frame |
| stat_valid_o | output | 1 | Status word valid (one cycle) |
| stat_o | output | LEN_W+5 | {length, overrun, oversize, non-octet, abort, CRC error} |
| disc_cnt_o | output | CNT_W | Rejected-frame counter |

## Verification
An error in the ones counter or in the seven-bit holding pipeline moves octet boundaries. That shows up at once in the first delivered byte of the frame, and in the non-octet or CRC bits of the status word when the frame closes. An address decision latched on the wrong byte shows up three octets later, as bytes where none were expected or as a discard count that is off by one. A wrong overrun or length count shows only in the status word, so every frame's status is compared as well as its bytes.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam int ERR_W    = 5;
  localparam int ERR_CRC  = 0;
  localparam int ERR_ABT  = 1;
  localparam int ERR_NOCT = 2;
  localparam int ERR_OVS  = 3;
  localparam int ERR_OVR  = 4;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    crc_step = {1'b0, c[15:1]} ^ (((c[0] ^ b) == 1'b1) ? CRC_POLY_R : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_bit_unstuff.sv
module hdlc_bit_unstuff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic flag_o,
  output logic abort_o
);
  logic [2:0] ones_q;

  assign bit_o = bit_i;

  always_comb begin
    bit_vld_o = 1'b0;
    flag_o    = 1'b0;
    abort_o   = 1'b0;
    if (en_i) begin
      if (bit_i) begin
        if (ones_q == 3'd6)      abort_o   = 1'b1;
        else if (ones_q != 3'd7) bit_vld_o = 1'b1;
      end else begin
        if (ones_q == 3'd6)                          flag_o    = 1'b1;
        else if (ones_q != 3'd5 && ones_q != 3'd7)   bit_vld_o = 1'b1;  // drop stuffed zero
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ones_q <= '0;
    else if (en_i) ones_q <= bit_i ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
  end

  // R7
  abort_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  // R2
  event_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_vld_o, flag_o, abort_o}));
endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 import hdlc_rx_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o,
  output logic        good_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_PRESET;
    else if (init_i) crc_q <= CRC_PRESET;
    else if (en_i)   crc_q <= crc_step(crc_q, bit_i);
  end

  assign crc_o  = crc_q;
  assign good_o = (crc_q == CRC_GOOD);

  // R3
  crc_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> crc_o == CRC_PRESET);
endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match #(
  parameter int ADDR_W = 16,
  parameter int N_ADDR = 4
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [ADDR_W-1:0]        mask_i,
  input  logic [N_ADDR*ADDR_W-1:0] match_i,
  output logic                     hit_o
);
  logic [N_ADDR-1:0] hit;

  for (genvar k = 0; k < N_ADDR; k++) begin : g_cmp
    assign hit[k] = (((addr_i ^ match_i[k*ADDR_W +: ADDR_W]) & mask_i) == '0);
  end

  assign hit_o = |hit;
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer import hdlc_rx_pkg::*; #(
  parameter int LEN_W  = 16,
  parameter int N_ADDR = 4,
  parameter int CNT_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_en_i,
  input  logic                     rx_bit_i,
  input  logic [LEN_W-1:0]         max_len_i,
  input  logic [15:0]              addr_mask_i,
  input  logic [N_ADDR*16-1:0]     addr_match_i,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic [7:0]               out_data_o,
  output logic                     out_first_o,
  output logic                     out_last_o,
  output logic                     stat_valid_o,
  output logic [LEN_W+ERR_W-1:0]   stat_o,
  output logic [CNT_W-1:0]         disc_cnt_o
);
  localparam int ST_W = LEN_W + ERR_W;
  localparam int PIPE = 7;  // bits of a flag emitted before it is recognised

  logic bvld, bval, flag, abrt;
  logic [PIPE-1:0] pipe_q;
  logic [2:0] pcnt_q;
  logic in_frame_q;
  logic [7:0] sh_q;
  logic [2:0] bcnt_q;
  logic [LEN_W-1:0] nbytes_q, len_q, nb_next;
  logic [2:0][7:0] dl_q;
  logic acc_q, ovs_q, ovr_q, hit, crc_good;
  logic [15:0] crc_val;
  logic out_valid_q, out_first_q, out_last_q, stat_valid_q;
  logic [7:0] out_data_q;
  logic [ST_W-1:0] stat_q;
  logic [CNT_W-1:0] disc_q;

  hdlc_bit_unstuff u_unstuff (
    .clk_i, .rst_ni, .en_i(rx_en_i), .bit_i(rx_bit_i),
    .bit_vld_o(bvld), .bit_o(bval), .flag_o(flag), .abort_o(abrt)
  );

  logic pop, pbit, fbit, byte_done;
  logic [7:0] new_byte;
  assign pop       = bvld && (pcnt_q == 3'(PIPE));
  assign pbit      = pipe_q[PIPE-1];
  assign fbit      = pop && in_frame_q;
  assign byte_done = fbit && (bcnt_q == 3'd7);
  assign new_byte  = {pbit, sh_q[7:1]};
  assign nb_next   = nbytes_q + LEN_W'(1);

  hdlc_crc16 u_crc (
    .clk_i, .rst_ni, .init_i(flag), .en_i(fbit), .bit_i(pbit),
    .crc_o(crc_val), .good_o(crc_good)
  );

  hdlc_addr_match #(.ADDR_W(16), .N_ADDR(N_ADDR)) u_match (
    .addr_i({new_byte, dl_q[0]}), .mask_i(addr_mask_i),
    .match_i(addr_match_i), .hit_o(hit)
  );

  logic take, ovs_set, deliver, end_ev, long_enough, aligned, report, flush;
  logic push, blocked, push_ok, ovr_now;
  assign take        = byte_done && !ovs_q && (nb_next <= max_len_i);
  assign ovs_set     = byte_done && !ovs_q && (nb_next > max_len_i);
  assign deliver     = take && acc_q && (nb_next >= LEN_W'(4));
  assign end_ev      = in_frame_q && (flag || abrt);
  assign long_enough = nbytes_q >= LEN_W'(4);
  assign aligned     = (bcnt_q == 3'd0);
  assign report      = end_ev && long_enough && acc_q;
  assign flush       = report && flag && aligned && !ovs_q;
  assign push        = deliver || flush;
  assign blocked     = out_valid_q && !out_ready_i;
  assign push_ok     = push && !blocked;
  assign ovr_now     = ovr_q || (push && blocked);

  logic [ERR_W-1:0] err;
  always_comb begin
    err           = '0;
    err[ERR_CRC]  = flag && aligned && !ovs_q && !crc_good;
    err[ERR_ABT]  = abrt;
    err[ERR_NOCT] = flag && !aligned;
    err[ERR_OVS]  = ovs_q;
    err[ERR_OVR]  = ovr_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0; pcnt_q <= '0; in_frame_q <= 1'b0;
      sh_q <= '0; bcnt_q <= '0; nbytes_q <= '0; len_q <= '0; dl_q <= '0;
      acc_q <= 1'b0; ovs_q <= 1'b0; ovr_q <= 1'b0;
    end else if (flag || abrt) begin
      pcnt_q     <= '0;
      in_frame_q <= flag;
      bcnt_q     <= '0;
      nbytes_q   <= '0;
      len_q      <= '0;
      acc_q      <= 1'b0;
      ovs_q      <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (bvld) begin
        pipe_q <= {pipe_q[PIPE-2:0], bval};
        if (pcnt_q != 3'(PIPE)) pcnt_q <= pcnt_q + 3'd1;
      end
      if (fbit) begin
        sh_q   <= new_byte;
        bcnt_q <= bcnt_q + 3'd1;
      end
      if (take) begin
        nbytes_q <= nb_next;
        dl_q     <= {dl_q[1:0], new_byte};
        if (nb_next == LEN_W'(2)) acc_q <= hit;
      end
      if (ovs_set) ovs_q <= 1'b1;
      if (push)    ovr_q <= ovr_now;
      if (push_ok) len_q <= len_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0; out_data_q <= '0; out_first_q <= 1'b0; out_last_q <= 1'b0;
      stat_valid_q <= 1'b0; stat_q <= '0; disc_q <= '0;
    end else begin
      if (push_ok) begin
        out_valid_q <= 1'b1;
        out_data_q  <= dl_q[2];
        out_first_q <= deliver && (nb_next == LEN_W'(4));
        out_last_q  <= flush;
      end else if (out_valid_q && out_ready_i) begin
        out_valid_q <= 1'b0;
      end
      stat_valid_q <= report;
      if (report) stat_q <= {len_q + LEN_W'(flush && push_ok), err};
      if (end_ev && long_enough && !acc_q) disc_q <= disc_q + CNT_W'(1);
    end
  end

  assign out_valid_o  = out_valid_q;
  assign out_data_o   = out_data_q;
  assign out_first_o  = out_first_q;
  assign out_last_o   = out_last_q;
  assign stat_valid_o = stat_valid_q;
  assign stat_o       = stat_q;
  assign disc_cnt_o   = disc_q;

  // R8
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  // R10
  disc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_cnt_o != $past(disc_cnt_o) |-> disc_cnt_o == $past(disc_cnt_o) + CNT_W'(1) && !stat_valid_o);
  // R1
  stat_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);
  // R5
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> stat_o[ST_W-1:ERR_W] <= max_len_i);
  // R9
  mask_zero_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && nb_next == LEN_W'(2) && addr_mask_i == 16'h0000 |=> acc_q);
endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_bit = 1'b1, ready = 1'b1;
  logic [15:0] max_len = 16'd64, mask = 16'h0000;
  logic [63:0] match = {16'h0F0F, 16'h5555, 16'hABCD, 16'h1234};
  logic out_valid, out_first, out_last, stat_valid;
  logic [7:0] out_data;
  logic [20:0] stat;
  logic [15:0] disc;

  always #2 clk = ~clk;  // 250 MHz

  hdlc_rx_deframer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rx_bit_i(rx_bit),
    .max_len_i(max_len), .addr_mask_i(mask), .addr_match_i(match),
    .out_ready_i(ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_first_o(out_first), .out_last_o(out_last), .stat_valid_o(stat_valid),
    .stat_o(stat), .disc_cnt_o(disc)
  );

  int n_chk = 0, n_bad = 0, ones = 0, disc_exp = 0;
  logic [9:0]  bq[$];
  string       btag[$];
  logic [20:0] sq[$];
  string       stag[$];
  logic [7:0]  fq[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops expectations as the design produces results
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && ready) begin
        if (bq.size() == 0) check("R1 unexpected byte", {22'd0, out_first, out_last, out_data}, 32'hFFFF);
        else check(btag.pop_front(), {22'd0, out_first, out_last, out_data}, {22'd0, bq.pop_front()});
      end
      if (stat_valid) begin
        if (sq.size() == 0) check("R10/R11 unexpected status", {11'd0, stat}, 32'hFFFF);
        else check(stag.pop_front(), {11'd0, stat}, {11'd0, sq.pop_front()});
      end
    end
  end

  task automatic exp_byte(input logic first, input logic last, input logic [7:0] d, input string tag);
    bq.push_back({first, last, d}); btag.push_back(tag);
  endtask
  task automatic exp_stat(input int len, input logic [4:0] err, input string tag);
    sq.push_back({16'(len), err}); stag.push_back(tag);
  endtask

  task automatic tx_bit(input logic b);
    rx_en = 1'b1; rx_bit = b;
    @(posedge clk); #1;
    rx_en = 1'b0;
    @(posedge clk); #1;
  endtask
  task automatic tx_data_bit(input logic b);
    tx_bit(b);
    if (b) begin
      ones++;
      if (ones == 5) begin tx_bit(1'b0); ones = 0; end
    end else ones = 0;
  endtask
  task automatic tx_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) tx_data_bit(d[i]);
  endtask
  task automatic tx_flag();
    for (int i = 0; i < 8; i++) tx_bit(hdlc_rx_pkg::FLAG_BYTE[i]);
    ones = 0;
  endtask

  // sends fq with FCS and closing flag; optionally predicts the result
  task automatic send_frame(input logic bad, input logic auto_exp, input string tag);
    logic [15:0] crc, fcs, addr;
    logic acc;
    int n;
    crc = 16'hFFFF;
    foreach (fq[j]) for (int i = 0; i < 8; i++) crc = hdlc_rx_pkg::crc_step(crc, fq[j][i]);
    fcs = ~crc;
    if (bad) fcs[0] = ~fcs[0];
    n = fq.size() + 2;
    if (auto_exp && n >= 4) begin
      addr = {fq[1], fq[0]};
      acc = (mask == 16'h0);
      for (int k = 0; k < 4; k++) if (((addr ^ match[k*16 +: 16]) & mask) == 16'h0) acc = 1'b1;
      if (!acc) disc_exp++;
      else if (n > int'(max_len)) begin
        for (int k = 0; k <= int'(max_len) - 4; k++) exp_byte(k == 0, 1'b0, fq[k], {tag, " R5 byte"});
        exp_stat(int'(max_len) - 3, 5'b01000, {tag, " R5 status"});
      end else begin
        for (int k = 0; k < fq.size(); k++) exp_byte(k == 0, k == fq.size() - 1, fq[k], {tag, " R1 byte"});
        exp_stat(fq.size(), {4'b0000, bad}, {tag, " R4 status"});
      end
    end
    foreach (fq[j]) tx_byte(fq[j]);
    tx_byte(fcs[7:0]);
    tx_byte(fcs[15:8]);
    tx_flag();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report_end();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 out_valid", {31'd0, out_valid}, 32'd0);
    check("R12 stat_valid", {31'd0, stat_valid}, 32'd0);
    check("R12 disc", {16'd0, disc}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 10; i++) tx_bit(1'b1);
    tx_flag();

    // R1 R2 R3: stuffing-heavy payload, mask 0 accepts all
    fq = '{8'h01, 8'h02, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
    send_frame(1'b0, 1'b1, "T1");
    tx_flag();  // empty frame between flags
    // R11 short frame
    fq = '{8'hAA};
    send_frame(1'b0, 1'b1, "T2");
    check("R11 disc after short", {16'd0, disc}, 32'd0);
    // R3 bad FCS
    fq = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
    send_frame(1'b1, 1'b1, "T3 R3");
    // R9 R10 filter
    mask = 16'hFFFF;
    fq = '{8'hCD, 8'hAB, 8'h01, 8'h02}; send_frame(1'b0, 1'b1, "T4a R9");
    fq = '{8'h0F, 8'h0F, 8'h03};        send_frame(1'b0, 1'b1, "T4b R9");
    fq = '{8'h22, 8'h11, 8'h04, 8'h05}; send_frame(1'b0, 1'b1, "T4c R10");
    repeat (4) @(posedge clk); #1;
    check("R10 disc after reject", {16'd0, disc}, 32'(disc_exp));
    mask = 16'hFF00;
    fq = '{8'h77, 8'h12, 8'h06};        send_frame(1'b0, 1'b1, "T4d R9");
    // R5 oversize
    mask = 16'h0000;
    max_len = 16'd12;
    fq.delete();
    for (int k = 0; k < 14; k++) fq.push_back(8'(8'h40 + k));
    send_frame(1'b0, 1'b1, "T5");
    max_len = 16'd64;
    // R7 abort after 5 complete bytes
    exp_byte(1'b1, 1'b0, 8'h81, "T6 R7 byte");
    exp_byte(1'b0, 1'b0, 8'h42, "T6 R7 byte");
    exp_stat(2, 5'b00010, "T6 R7 status");
    fq = '{8'h81, 8'h42, 8'hC3, 8'h24, 8'h5A, 8'h00};
    foreach (fq[j]) tx_byte(fq[j]);
    for (int i = 0; i < 8; i++) tx_bit(1'b1);
    ones = 0;
    tx_flag();
    // R6 non-octet: 5 bytes plus 3 bits
    exp_byte(1'b1, 1'b0, 8'h11, "T7 R6 byte");
    exp_byte(1'b0, 1'b0, 8'h22, "T7 R6 byte");
    exp_stat(2, 5'b00100, "T7 R6 status");
    fq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    foreach (fq[j]) tx_byte(fq[j]);
    tx_data_bit(1'b0); tx_data_bit(1'b1); tx_data_bit(1'b0);
    tx_flag();
    // R8 overrun: sink stalled for the whole frame
    ready = 1'b0;
    exp_byte(1'b1, 1'b0, 8'hA1, "T8 R8 held byte");
    exp_stat(1, 5'b10000, "T8 R8 status");
    fq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6};
    send_frame(1'b0, 1'b0, "T8");
    repeat (4) @(posedge clk); #1;
    check("R8 held valid", {31'd0, out_valid}, 32'd1);
    check("R8 held data", {24'd0, out_data}, 32'hA1);
    ready = 1'b1;
    repeat (40) @(posedge clk); #1;
    check("R1 bytes outstanding", 32'(bq.size()), 32'd0);
    check("R4 status outstanding", 32'(sq.size()), 32'd0);
    check("R10 final disc", {16'd0, disc}, 32'(disc_exp));
    report_end();
  end
endmodule